// File: doc/BRIEF.md
# Endpoint Status Register with Write-One-to-Clear Flags

This block is one memory-mapped status word of a USB device controller, plus the
interrupt enable word that goes with it. The status word holds a set of event
flags and one endpoint arm bit. The USB engine raises the event flags with
single-cycle pulses. Firmware clears a flag by writing a one to its bit
position. Firmware sets the arm bit to tell the engine that an IN endpoint holds
data ready for the host. When the engine reports that the packet has gone out,
the block clears the arm bit and raises the packet-sent flag, which can drive
the interrupt.

The arm bit is an ordinary read/write bit that sits among clear-on-one bits.
Firmware therefore clears other flags with a read-modify-write, and that write
carries the arm value back. If the packet goes out between the read and the
write, a plain register would re-arm an endpoint that is already empty. To stop
this, the status word also carries a read-only sequence tag that steps on every
hardware clear. A write that sets the arm bit takes effect only when the tag
field in its data matches the current tag. A stale write-back is dropped, while
the flag clears in that same write still apply.

The interrupt output is registered. It is the OR, over all event flags, of each
flag ANDed with its enable bit.

Top module: `ep_status_reg`

## Requirements
- R1: After an active-low reset, every event flag, the arm bit, the sequence tag, the enable bits and irq_o are zero.
- R2: A pulse on tx_done_i sets flag bit 0 of the status word at address 0. A pulse on evt_i[k] sets flag bit k+1. The new value can be read in the cycle after the pulse.
- R3: A write to address 0 clears each flag in bits 3:0 whose write data bit is 1. A flag whose write data bit is 0 keeps its value.
- R4: If an event pulse and a write-one-to-clear of the same flag fall in the same cycle, the flag ends up set.
- R5: Writing 0 to bit 4 (arm) at address 0 always clears the arm bit, so an all-zero write clears arm and leaves the flags alone. Writing 1 to bit 4 sets arm when write data bits 8:5 equal the current sequence tag.
- R6: Each tx_done_i pulse clears the arm bit and adds one, modulo 16, to the sequence tag. The tag reads back in bits 8:5 of address 0 and changes at no other time.
- R7: A tx_done_i pulse that falls in the same cycle as a write setting the arm bit leaves the arm bit cleared.
- R8: A write with bit 4 set and bits 8:5 different from the current tag leaves the arm bit unchanged.
- R9: Address 1 holds four enable bits in bits 3:0, one per flag in the same order. They are read/write, and the other bits of that word read as zero.
- R10: irq_o goes high one cycle after a clock edge at which some flag and its enable bit are both 1, and goes low one cycle after an edge at which no such pair exists.
- R11: Reads of addresses other than 0 and 1 return zero. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| tx_done_i | input | 1 | Engine pulse: the IN packet was delivered |
| evt_i | input | NUM_EVT-1 | Engine pulses for the other event flags |
| irq_o | output | 1 | Registered interrupt request |

## Verification
A write, an event pulse or a packet-sent pulse updates the status and enable
words at the next clock edge. Because the read port is combinational, the bench
sets the read address at the following falling edge and samples a moment later.
irq_o lags the flags by one more register. The bench samples it half a cycle
after the edge that updates the flags, where the old level must still show, and
again one cycle later, where the new level must show. Same-cycle collisions
(event against clear, packet-sent against arm) are driven on a single falling
edge, so both inputs reach the same rising edge.

// File: rtl/ep_stat_pkg.sv
package ep_stat_pkg;
  localparam int unsigned STAT_OFFS = 0;
  localparam int unsigned EN_OFFS   = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_EN   = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/ep_addr_dec.sv
module ep_addr_dec
  import ep_stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(STAT_OFFS))    sel_o = SEL_STAT;
    else if (addr_i == ADDR_W'(EN_OFFS)) sel_o = SEL_EN;
    else                                 sel_o = SEL_NONE;
  end
endmodule

// File: rtl/ep_evt_bank.sv
module ep_evt_bank #(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] flags_o
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q <= 1'b0;
      else if (set_i[i]) flag_q <= 1'b1;  // set beats clear
      else if (clr_i[i]) flag_q <= 1'b0;
    end
    assign flags_o[i] = flag_q;
  end
endmodule

// File: rtl/ep_arm_ctrl.sv
module ep_arm_ctrl #(
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_arm_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             hw_clr_i,
  output logic             arm_o,
  output logic [TAG_W-1:0] tag_o
);
  logic             arm_q;
  logic [TAG_W-1:0] tag_q;
  logic             tag_ok;

  assign tag_ok = (wr_tag_i == tag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      tag_q <= '0;
    end else if (hw_clr_i) begin
      arm_q <= 1'b0;
      tag_q <= tag_q + TAG_W'(1);
    end else if (wr_i) begin
      if (!wr_arm_i)   arm_q <= 1'b0;
      else if (tag_ok) arm_q <= 1'b1;
      // stale tag: keep arm_q
    end
  end

  assign arm_o = arm_q;
  assign tag_o = tag_q;
endmodule

// File: rtl/ep_irq_gen.sv
module ep_irq_gen #(
  parameter int unsigned NUM_EVT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] flags_i,
  input  logic [NUM_EVT-1:0] en_i,
  output logic               irq_o
);
  logic irq_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(flags_i & en_i);
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/ep_status_reg.sv
module ep_status_reg
  import ep_stat_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned TAG_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic               tx_done_i,
  input  logic [NUM_EVT-2:0] evt_i,
  output logic               irq_o
);
  localparam int unsigned ARM_BIT = NUM_EVT;
  localparam int unsigned TAG_LSB = NUM_EVT + 1;
  localparam int unsigned USED_W  = TAG_LSB + TAG_W;

  reg_sel_e           sel;
  logic               wr_stat, wr_en;
  logic [NUM_EVT-1:0] flags_q, en_q, clr_vec;
  logic               arm_q;
  logic [TAG_W-1:0]   tag_q;
  logic [DATA_W-1:0]  stat_word, en_word;
  logic               unused_wdata;

  ep_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr_stat = we_i && (sel == SEL_STAT);
  assign wr_en   = we_i && (sel == SEL_EN);
  assign clr_vec = wr_stat ? wdata_i[NUM_EVT-1:0] : '0;

  ep_evt_bank #(.NUM_EVT(NUM_EVT)) u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   ({evt_i, tx_done_i}),
    .clr_i   (clr_vec),
    .flags_o (flags_q)
  );

  ep_arm_ctrl #(.TAG_W(TAG_W)) u_arm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_stat),
    .wr_arm_i (wdata_i[ARM_BIT]),
    .wr_tag_i (wdata_i[TAG_LSB +: TAG_W]),
    .hw_clr_i (tx_done_i),
    .arm_o    (arm_q),
    .tag_o    (tag_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= '0;
    else if (wr_en) en_q <= wdata_i[NUM_EVT-1:0];
  end

  ep_irq_gen #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags_q),
    .en_i    (en_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    stat_word                      = '0;
    stat_word[NUM_EVT-1:0]         = flags_q;
    stat_word[ARM_BIT]             = arm_q;
    stat_word[TAG_LSB +: TAG_W]    = tag_q;
    en_word                        = '0;
    en_word[NUM_EVT-1:0]           = en_q;
  end

  always_comb begin
    unique case (sel)
      SEL_STAT: rdata_o = stat_word;
      SEL_EN:   rdata_o = en_word;
      default:  rdata_o = '0;
    endcase
  end

  assign unused_wdata = ^wdata_i[DATA_W-1:USED_W];
endmodule

// File: rtl/ep_status_reg_chk.sv
module ep_status_reg_chk #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned TAG_W   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               we_i,
  input logic [DATA_W-1:0]  wdata_i,
  input logic               tx_done_i,
  input logic [NUM_EVT-2:0] evt_i,
  input logic [NUM_EVT-1:0] flags_q,
  input logic [NUM_EVT-1:0] en_q,
  input logic               arm_q,
  input logic [TAG_W-1:0]   tag_q,
  input logic               irq_o
);
  localparam int unsigned ARM_BIT = NUM_EVT;
  localparam int unsigned TAG_LSB = NUM_EVT + 1;

  logic wr_stat, tag_hit;
  assign wr_stat = we_i && (addr_i == ADDR_W'(ep_stat_pkg::STAT_OFFS));
  assign tag_hit = (wdata_i[TAG_LSB +: TAG_W] == tag_q);

  AST_TX_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> flags_q[0]);  // R2
  AST_EVT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[0] |=> flags_q[1]);  // R2
  AST_SET_BEATS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && wr_stat && wdata_i[0]) |=> flags_q[0]);  // R4
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[0] && !tx_done_i) |=> !flags_q[0]);  // R3
  AST_W0_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_q[1] && !(wr_stat && wdata_i[1])) |=> flags_q[1]);  // R3
  AST_ARM_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[ARM_BIT] && tag_hit && !tx_done_i) |=> arm_q);  // R5
  AST_ARM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !wdata_i[ARM_BIT]) |=> !arm_q);  // R5
  AST_TAG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> (tag_q == $past(tag_q) + TAG_W'(1)));  // R6
  AST_TAG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_done_i |=> $stable(tag_q));  // R6
  AST_HW_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> !arm_q);  // R7
  AST_STALE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[ARM_BIT] && !tag_hit) |=> $stable(arm_q) || !arm_q);  // R8
  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flags_q & en_q)) |=> irq_o);  // R10
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flags_q & en_q)) |=> !irq_o);  // R10
endmodule

bind ep_status_reg ep_status_reg_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .TAG_W(TAG_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .we_i      (we_i),
  .wdata_i   (wdata_i),
  .tx_done_i (tx_done_i),
  .evt_i     (evt_i),
  .flags_q   (flags_q),
  .en_q      (en_q),
  .arm_q     (arm_q),
  .tag_q     (tag_q),
  .irq_o     (irq_o)
);

// File: tb/tb_ep_status_reg.sv
`timescale 1ns/1ps
module tb_ep_status_reg;
  localparam int unsigned DATA_W  = 16;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NUM_EVT = 4;
  localparam int unsigned TAG_W   = 4;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [ADDR_W-1:0]  addr_i = '0;
  logic               we_i = 1'b0;
  logic [DATA_W-1:0]  wdata_i = '0;
  logic [DATA_W-1:0]  rdata_o;
  logic               tx_done_i = 1'b0;
  logic [NUM_EVT-2:0] evt_i = '0;
  logic               irq_o;

  always #10 clk_i = ~clk_i;  // 50 MHz

  ep_status_reg #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .TAG_W(TAG_W)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .tx_done_i(tx_done_i), .evt_i(evt_i), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    total = 0;
  int    bad   = 0;
  bit    done  = 1'b0;
  event  sample_ev;

  // monitor: pops one expected item per sample request
  initial begin
    forever begin
      @(sample_ev);
      #1;
      if (q.size() != 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = it.is_irq ? {15'd0, irq_o} : rdata_o;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic push_now(bit is_irq, logic [15:0] exp, string req);
    item_t it;
    it.is_irq = is_irq; it.exp = exp; it.req = req;
    q.push_back(it);
    -> sample_ev;
    #2;
  endtask

  task automatic chk_rd(logic [ADDR_W-1:0] a, logic [15:0] exp, string req);
    @(negedge clk_i);
    addr_i = a;
    push_now(1'b0, exp, req);
  endtask

  task automatic chk_irq(bit exp, string req);
    @(negedge clk_i);
    push_now(1'b1, {15'd0, exp}, req);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic pulse(bit tx, logic [NUM_EVT-2:0] ev);
    @(negedge clk_i);
    tx_done_i = tx; evt_i = ev;
    @(negedge clk_i);
    tx_done_i = 1'b0; evt_i = '0;
  endtask

  // event pulse and write on the same edge
  task automatic pulse_wr(bit tx, logic [NUM_EVT-2:0] ev, logic [15:0] d);
    @(negedge clk_i);
    tx_done_i = tx; evt_i = ev; addr_i = '0; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    tx_done_i = 1'b0; evt_i = '0; we_i = 1'b0; wdata_i = '0;
  endtask

  initial begin
    #50000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk_rd(4'd0, 16'h0000, "R1 status after reset");
    chk_rd(4'd1, 16'h0000, "R1 enable after reset");
    chk_irq(1'b0, "R1 irq after reset");

    pulse(1'b0, 3'b001);
    chk_rd(4'd0, 16'h0002, "R2 evt0 sets bit1");
    pulse(1'b0, 3'b100);
    chk_rd(4'd0, 16'h000A, "R2 evt2 sets bit3");

    wr(4'd0, 16'h0002);
    chk_rd(4'd0, 16'h0008, "R3 w1c bit1");
    wr(4'd0, 16'h0000);
    chk_rd(4'd0, 16'h0008, "R3 zero write keeps flags");

    pulse_wr(1'b0, 3'b100, 16'h0008);
    chk_rd(4'd0, 16'h0008, "R4 set beats clear");
    wr(4'd0, 16'h0008);
    chk_rd(4'd0, 16'h0000, "R3 w1c bit3");

    wr(4'd0, 16'h0010);
    chk_rd(4'd0, 16'h0010, "R5 arm with tag 0");
    pulse(1'b1, 3'b000);
    chk_rd(4'd0, 16'h0021, "R6 tx clears arm, flag0, tag 1");
    wr(4'd0, 16'h0010);
    chk_rd(4'd0, 16'h0021, "R8 stale tag ignored");
    wr(4'd0, 16'h0030);
    chk_rd(4'd0, 16'h0031, "R5 arm with tag 1");
    pulse_wr(1'b1, 3'b000, 16'h0030);
    chk_rd(4'd0, 16'h0041, "R7 hw clear wins");
    wr(4'd0, 16'h0050);
    chk_rd(4'd0, 16'h0051, "R5 arm with tag 2");
    wr(4'd0, 16'h0000);
    chk_rd(4'd0, 16'h0041, "R5 all-zero write clears arm only");

    wr(4'd1, 16'hFFFF);
    chk_rd(4'd1, 16'h000F, "R9 enable readback");
    chk_irq(1'b1, "R10 irq high with flag0 enabled");
    // clear flag0; irq lags by one cycle
    @(negedge clk_i);
    addr_i = 4'd0; wdata_i = 16'h0001; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
    push_now(1'b1, 16'h0001, "R10 irq still high one cycle");
    chk_irq(1'b0, "R10 irq low after flags cleared");
    chk_rd(4'd0, 16'h0040, "R3 flag0 cleared");

    wr(4'd1, 16'h0002);
    pulse(1'b1, 3'b000);
    chk_rd(4'd0, 16'h0061, "R6 tag 3");
    chk_irq(1'b0, "R10 masked flag0 gives no irq");
    pulse(1'b0, 3'b001);
    chk_irq(1'b1, "R10 enabled flag1 gives irq");

    chk_rd(4'd2, 16'h0000, "R11 unmapped read");
    wr(4'd3, 16'hFFFF);
    chk_rd(4'd0, 16'h0063, "R11 unmapped write: status");
    chk_rd(4'd1, 16'h0002, "R11 unmapped write: enable");

    pulse(1'b1, 3'b000);
    chk_rd(4'd0, 16'h0083, "R6 tag 4");
    for (int i = 0; i < 15; i++) pulse(1'b1, 3'b000);
    chk_rd(4'd0, 16'h0063, "R6 tag wraps mod 16");

    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule